// File: doc/BRIEF.md
# Vectored Nested Priority Interrupt Controller

This block arbitrates interrupt sources for two classes, a normal class and a fast class. Each class gets a status vector that has already been masked. Every source carries a 3-bit priority, and level 0 is the most urgent. For each class the controller picks the most urgent pending source. It raises the class request only when that source is strictly more urgent than the level at the top of the class's in-service stack. It also presents a vector word that combines a software base address with the index of the chosen source, so every source can have its own service routine.

The processor acknowledges a request with the class's ack strobe. The ack pushes the winner's priority onto that class's stack, which holds up to eight levels. The end-of-service strobe pops the stack. The fast class always wins over the normal class. The normal request is held low while the fast class is requesting or has anything in service.

Each class has its own vectoring enable bit. When the bit is clear, that class behaves as a plain OR of its status bits and its vector shows only the base.

Top module: `vic_top`

## Requirements
- R1: After reset the control word, base and all priorities are zero and both stack depths are zero. Both classes are non-vectored, so each request equals the OR of its status bits and each vector reads zero.
- R2: Control register (address 0) bit 0 enables vectoring for the normal class, and bit 1 enables it for the fast class. Each bit affects only its own class.
- R3: Each vector word has bits 31:23 zero, the base register (address 1, bits 15:0) in bits 22:7, the winning source index in bits 6:2, and bits 1:0 zero. The index field is zero when no source qualifies.
- R4: Priority word k (address 2+k) holds source 8k+j in bits 4j+2:4j. The winner is the pending source with the smallest priority value. When values are equal, the lowest source index wins.
- R5: In vectored mode a source qualifies only when its priority value is strictly less than the stack top. An empty stack admits any level. The request is high exactly when some source qualifies.
- R6: An ack while the class request is high pushes the winner's priority onto the stack, and the depth rises by one on the next cycle.
- R7: An end-of-service strobe lowers the depth by one when the stack is not empty. On an empty stack it has no effect. A pop takes precedence over a simultaneous push.
- R8: In non-vectored mode the request is the OR of the status bits, the vector equals the base shifted to bits 22:7, and ack does not change the depth.
- R9: The normal request is forced low while the fast request is high or the fast stack depth is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 32 | Register write data |
| nrm_stat | input | NSRC | Enabled pending status, normal class |
| fst_stat | input | NSRC | Enabled pending status, fast class |
| nrm_ack | input | 1 | Normal request taken, push |
| fst_ack | input | 1 | Fast request taken, push |
| nrm_eos | input | 1 | Normal end of service, pop |
| fst_eos | input | 1 | Fast end of service, pop |
| nrm_req | output | 1 | Normal interrupt request |
| fst_req | output | 1 | Fast interrupt request |
| nrm_vec | output | 32 | Normal vector word |
| fst_vec | output | 32 | Fast vector word |
| nrm_depth | output | 4 | Normal in-service depth |
| fst_depth | output | 4 | Fast in-service depth |

## Verification
The hardest situation to reach from the ports is a deep, partly filled stack whose top level hides some pending sources while still admitting a more urgent one. Reaching it takes a run of acks at strictly falling levels, with pops mixed in. Sparse random status vectors, frequent acks, rarer end-of-service strobes and occasional reprogramming of priorities and control produce many such stack shapes. A bench model tracks both stacks and predicts every request, vector and depth on each cycle. Directed steps first cover equal-priority ties, equal-level blocking and fast-over-normal gating.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int PRIO_W  = 3;
    localparam int NEST    = 8;
    localparam int DEPTH_W = $clog2(NEST + 1);
    localparam int PTR_W   = $clog2(NEST);
    localparam int IDX_W   = 5;
    localparam int BASE_W  = 16;
    localparam int LIMIT_W = PRIO_W + 1;
    localparam int SRC_PER_WORD = 8;
    localparam int ADR_CTRL  = 0;
    localparam int ADR_BASE  = 1;
    localparam int ADR_PRIO0 = 2;
    localparam int CTL_NRM = 0;
    localparam int CTL_FST = 1;

    typedef logic [PRIO_W-1:0] prio_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
        prio_t            lvl;
    } pick_t;

    function automatic logic [31:0] pack_vec(input logic [BASE_W-1:0] base,
                                             input logic [IDX_W-1:0] idx);
        return {9'd0, base, idx, 2'b00};
    endfunction
endpackage

// File: rtl/vic_pick.sv
module vic_pick
    import vic_pkg::*;
#(
    parameter int NSRC = 16
) (
    input  logic [NSRC-1:0]        stat,
    input  logic [NSRC*PRIO_W-1:0] prio,
    input  logic [LIMIT_W-1:0]     limit,
    output pick_t                  pick
);
    always_comb begin
        pick = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (stat[i] && ({1'b0, prio[i*PRIO_W +: PRIO_W]} < limit) &&
                (!pick.hit || prio[i*PRIO_W +: PRIO_W] < pick.lvl)) begin
                pick.hit = 1'b1;
                pick.idx = IDX_W'(i);
                pick.lvl = prio[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/vic_stack.sv
module vic_stack
    import vic_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               push,
    input  logic               pop,
    input  prio_t              push_lvl,
    output prio_t              top,
    output logic [DEPTH_W-1:0] depth
);
    prio_t              mem [NEST];
    logic [DEPTH_W-1:0] depth_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            depth_q <= '0;
        end else if (pop && depth_q != '0) begin
            depth_q <= depth_q - DEPTH_W'(1);
        end else if (push && depth_q < DEPTH_W'(NEST)) begin
            mem[depth_q[PTR_W-1:0]] <= push_lvl;
            depth_q <= depth_q + DEPTH_W'(1);
        end
    end

    assign top   = (depth_q == '0) ? '0 : mem[PTR_W'(depth_q - DEPTH_W'(1))];
    assign depth = depth_q;

    // R5: a nested entry is always more urgent than the one beneath it
    p_push_nested_r5: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && depth_q != '0) |-> (push_lvl < top));

    // R6: push grows the stack by one
    p_push_grow_r6: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && depth_q < DEPTH_W'(NEST)) |=> (depth_q == $past(depth_q) + DEPTH_W'(1)));

    // R7: pop shrinks a non-empty stack by one
    p_pop_shrink_r7: assert property (@(posedge clk) disable iff (rst)
        (pop && depth_q != '0) |=> (depth_q == $past(depth_q) - DEPTH_W'(1)));

    // R7: pop on an empty stack leaves it empty
    p_pop_empty_r7: assert property (@(posedge clk) disable iff (rst)
        (pop && depth_q == '0 && !push) |=> (depth_q == '0));
endmodule

// File: rtl/vic_class.sv
module vic_class
    import vic_pkg::*;
#(
    parameter int NSRC = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   vec_en,
    input  logic [NSRC-1:0]        stat,
    input  logic [NSRC*PRIO_W-1:0] prio,
    input  logic                   ack,
    input  logic                   eos,
    input  logic                   inhibit,
    output logic                   req,
    output logic [IDX_W-1:0]       idx,
    output logic [DEPTH_W-1:0]     depth
);
    pick_t              pick;
    prio_t              top;
    logic [LIMIT_W-1:0] limit;
    logic               raw_req;
    logic               push;

    assign limit = (depth == '0) ? LIMIT_W'(NEST) : {1'b0, top};

    vic_pick #(.NSRC(NSRC)) u_pick (
        .stat  (stat),
        .prio  (prio),
        .limit (limit),
        .pick  (pick)
    );

    assign raw_req = vec_en ? (pick.hit && depth < DEPTH_W'(NEST)) : (|stat);
    assign req     = raw_req && !inhibit;
    assign push    = vec_en && ack && req;
    assign idx     = vec_en ? pick.idx : '0;

    vic_stack u_stack (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .pop      (eos),
        .push_lvl (pick.lvl),
        .top      (top),
        .depth    (depth)
    );
endmodule

// File: rtl/vic_top.sv
module vic_top
    import vic_pkg::*;
#(
    parameter int NSRC   = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [NSRC-1:0]   nrm_stat,
    input  logic [NSRC-1:0]   fst_stat,
    input  logic              nrm_ack,
    input  logic              fst_ack,
    input  logic              nrm_eos,
    input  logic              fst_eos,
    output logic              nrm_req,
    output logic              fst_req,
    output logic [31:0]       nrm_vec,
    output logic [31:0]       fst_vec,
    output logic [3:0]        nrm_depth,
    output logic [3:0]        fst_depth
);
    localparam int NPW = (NSRC + SRC_PER_WORD - 1) / SRC_PER_WORD;

    logic [1:0]             ctrl_q;
    logic [BASE_W-1:0]      base_q;
    prio_t                  prio_q [NSRC];
    logic [NSRC*PRIO_W-1:0] prio_flat;
    logic [IDX_W-1:0]       nrm_idx, fst_idx;
    logic [DEPTH_W-1:0]     nrm_dep, fst_dep;
    logic                   unused_wdata;

    assign unused_wdata = ^bus_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            base_q <= '0;
            for (int s = 0; s < NSRC; s++) prio_q[s] <= '0;
        end else if (bus_we) begin
            if (bus_addr == ADDR_W'(ADR_CTRL)) ctrl_q <= bus_wdata[1:0];
            if (bus_addr == ADDR_W'(ADR_BASE)) base_q <= bus_wdata[BASE_W-1:0];
            for (int s = 0; s < NSRC; s++) begin
                if (bus_addr == ADDR_W'(ADR_PRIO0 + s / SRC_PER_WORD))
                    prio_q[s] <= bus_wdata[4*(s % SRC_PER_WORD) +: PRIO_W];
            end
        end
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_flat
        assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q[g];
    end

    vic_class #(.NSRC(NSRC)) u_fast (
        .clk     (clk),
        .rst     (rst),
        .vec_en  (ctrl_q[CTL_FST]),
        .stat    (fst_stat),
        .prio    (prio_flat),
        .ack     (fst_ack),
        .eos     (fst_eos),
        .inhibit (1'b0),
        .req     (fst_req),
        .idx     (fst_idx),
        .depth   (fst_dep)
    );

    vic_class #(.NSRC(NSRC)) u_norm (
        .clk     (clk),
        .rst     (rst),
        .vec_en  (ctrl_q[CTL_NRM]),
        .stat    (nrm_stat),
        .prio    (prio_flat),
        .ack     (nrm_ack),
        .eos     (nrm_eos),
        .inhibit (fst_req || fst_dep != '0),
        .req     (nrm_req),
        .idx     (nrm_idx),
        .depth   (nrm_dep)
    );

    assign nrm_vec   = pack_vec(base_q, nrm_idx);
    assign fst_vec   = pack_vec(base_q, fst_idx);
    assign nrm_depth = 4'(nrm_dep);
    assign fst_depth = 4'(fst_dep);

    // R9: fast class in service or requesting keeps normal requests off
    p_fast_over_normal_r9: assert property (@(posedge clk) disable iff (rst)
        (fst_dep != '0) |-> !nrm_req);

    // R8: non-vectored class never gains depth from an ack
    p_plain_no_push_r8: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q[CTL_FST] && !fst_eos) |=> (fst_dep <= $past(fst_dep)));
endmodule

// File: tb/vic_top_test.sv
`timescale 1ns/1ps
module vic_top_test;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_we;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [N-1:0] nrm_stat, fst_stat;
    logic        nrm_ack, fst_ack, nrm_eos, fst_eos;
    logic        nrm_req, fst_req;
    logic [31:0] nrm_vec, fst_vec;
    logic [3:0]  nrm_depth, fst_depth;

    int checks = 0;
    int bad = 0;
    bit done = 0;

    logic [2:0]  pm [N];
    logic [1:0]  cm;
    logic [15:0] bm;
    logic [2:0]  ns [8];
    logic [2:0]  fs [8];
    int          nd, fd;

    always #2.5 clk = ~clk;

    vic_top #(.NSRC(N), .ADDR_W(4)) uut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .nrm_stat(nrm_stat), .fst_stat(fst_stat),
        .nrm_ack(nrm_ack), .fst_ack(fst_ack), .nrm_eos(nrm_eos),
        .fst_eos(fst_eos), .nrm_req(nrm_req), .fst_req(fst_req),
        .nrm_vec(nrm_vec), .fst_vec(fst_vec), .nrm_depth(nrm_depth),
        .fst_depth(fst_depth)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_pick(input logic en, input logic [N-1:0] st,
                              input int dep, input logic [2:0] tp,
                              output logic rq, output logic [4:0] ix,
                              output logic [2:0] lv);
        int lim;
        lim = (dep == 0) ? 8 : int'(tp);
        rq = 1'b0; ix = '0; lv = '0;
        if (!en) begin
            rq = |st;
            return;
        end
        for (int i = 0; i < N; i++) begin
            if (st[i] && int'(pm[i]) < lim && (!rq || pm[i] < lv)) begin
                rq = 1'b1; ix = 5'(i); lv = pm[i];
            end
        end
        if (dep >= 8) rq = 1'b0;
    endtask

    task automatic wr(input int addr, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = 4'(addr); bus_wdata = d;
        @(posedge clk);
        if (addr == 0) cm = d[1:0];
        if (addr == 1) bm = d[15:0];
        for (int s = 0; s < N; s++)
            if (addr == 2 + s / 8) pm[s] = d[4*(s%8) +: 3];
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic step(input logic [N-1:0] nst, input logic [N-1:0] fst,
                        input logic na, input logic fa, input logic ne,
                        input logic fe, input string tag);
        logic frq, nraw, nrq;
        logic [4:0] fix, nix;
        logic [2:0] flv, nlv;
        nrm_stat = nst; fst_stat = fst; nrm_ack = na; fst_ack = fa;
        nrm_eos = ne; fst_eos = fe;
        #1;
        model_pick(cm[1], fst, fd, (fd > 0) ? fs[fd-1] : 3'd0, frq, fix, flv);
        model_pick(cm[0], nst, nd, (nd > 0) ? ns[nd-1] : 3'd0, nraw, nix, nlv);
        nrq = nraw && !frq && fd == 0;
        chk(tag, "fst_req", 32'(fst_req), 32'(frq));
        chk(tag, "nrm_req", 32'(nrm_req), 32'(nrq));
        chk(tag, "fst_vec", fst_vec, {9'd0, bm, fix, 2'b00});
        chk(tag, "nrm_vec", nrm_vec, {9'd0, bm, nix, 2'b00});
        chk(tag, "fst_depth", 32'(fst_depth), 32'(fd));
        chk(tag, "nrm_depth", 32'(nrm_depth), 32'(nd));
        @(posedge clk);
        if (fe && fd > 0) fd--;
        else if (cm[1] && fa && frq) begin fs[fd] = flv; fd++; end
        if (ne && nd > 0) nd--;
        else if (cm[0] && na && nrq) begin ns[nd] = nlv; nd++; end
        @(negedge clk);
        nrm_ack = 1'b0; fst_ack = 1'b0; nrm_eos = 1'b0; fst_eos = 1'b0;
    endtask

    task automatic set_prios();
        logic [31:0] w0, w1;
        w0 = '0; w1 = '0;
        for (int s = 0; s < 8; s++) w0[4*s +: 3] = pm[s];
        for (int s = 8; s < 16; s++) w1[4*(s-8) +: 3] = pm[s];
        wr(2, w0);
        wr(3, w1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired act=1 exp=0");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        cm = '0; bm = '0; nd = 0; fd = 0;
        for (int s = 0; s < N; s++) pm[s] = '0;
        rst = 1'b1; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        nrm_stat = '0; fst_stat = '0;
        nrm_ack = 0; fst_ack = 0; nrm_eos = 0; fst_eos = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state, plain OR requests, zero vectors
        step(16'h0010, 16'h0000, 0, 0, 0, 0, "R1");
        step(16'h0000, 16'h0100, 0, 0, 0, 0, "R1");

        // R8: non-vectored ack leaves depth alone, vector is base only
        wr(1, 32'h0000ABCD);
        step(16'h0030, 16'h0000, 1, 0, 0, 0, "R8");
        step(16'h0030, 16'h0000, 0, 0, 0, 0, "R8");
        chk("R8", "nrm_vec base", nrm_vec, 32'h0055E680);

        // R4: prio table, tie between src3 and src5
        for (int s = 0; s < N; s++) pm[s] = 3'd6;
        pm[3] = 3'd2; pm[5] = 3'd2; pm[9] = 3'd4; pm[12] = 3'd1;
        set_prios();
        wr(0, 32'h1);
        step(16'h0028, 16'h0000, 0, 0, 0, 0, "R4");
        // R3: vector packing with index 3
        nrm_stat = 16'h0028; #1;
        chk("R3", "nrm_vec pack", nrm_vec, {9'd0, 16'hABCD, 5'd3, 2'b00});
        // R2: only normal class vectored; fast stays plain
        step(16'h0028, 16'h0200, 0, 0, 0, 0, "R2");
        chk("R9", "nrm_req gated", 32'(nrm_req), 32'd0);

        // R6: push src3 (prio 2)
        step(16'h0008, 16'h0000, 1, 0, 0, 0, "R6");
        chk("R6", "nrm_depth", 32'(nrm_depth), 32'd1);
        // R5: equal level blocked, more urgent admitted
        step(16'h0020, 16'h0000, 0, 0, 0, 0, "R5");
        chk("R5", "equal blocked", 32'(nrm_req), 32'd0);
        step(16'h1020, 16'h0000, 0, 0, 0, 0, "R5");
        nrm_stat = 16'h1020; #1;
        chk("R5", "urgent idx", nrm_vec, {9'd0, 16'hABCD, 5'd12, 2'b00});
        // R7: pop then pop on empty
        step(16'h0000, 16'h0000, 0, 0, 1, 0, "R7");
        step(16'h0000, 16'h0000, 0, 0, 1, 0, "R7");
        chk("R7", "empty pop", 32'(nrm_depth), 32'd0);

        // R9: fast vectored preempts normal
        wr(0, 32'h3);
        step(16'h1000, 16'h0200, 0, 1, 0, 0, "R9");
        step(16'h1000, 16'h0000, 0, 0, 0, 0, "R9");
        chk("R9", "fast depth blocks", 32'(nrm_req), 32'd0);
        step(16'h1000, 16'h0000, 0, 0, 0, 1, "R9");
        step(16'h1000, 16'h0000, 0, 0, 0, 0, "R9");
        chk("R9", "normal back", 32'(nrm_req), 32'd1);

        // random phase
        for (int k = 0; k < 4000; k++) begin
            if (k % 500 == 250) begin
                for (int s = 0; s < N; s++) pm[s] = 3'($urandom_range(0, 7));
                set_prios();
            end
            if (k % 700 == 0) wr(0, 32'($urandom_range(1, 3)));
            step(16'($urandom & $urandom), 16'($urandom & $urandom & $urandom),
                 ($urandom_range(0, 2) == 0), ($urandom_range(0, 2) == 0),
                 ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0), "R5");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule